// File: doc/BRIEF.md
# Dual-Clock Show-Ahead FIFO

This block moves 16-bit words from a fast write clock domain into a slow read clock domain whose clock has no fixed phase relation to the write clock. It holds up to eight words. The producer presents a word with a write strobe and watches a Full flag in its own domain. The consumer sees the oldest stored word on the output at all times, without asking for it first. It pulses an acknowledge once it has taken that word, and it watches an Empty flag in its own domain. While nothing is stored, the output reads as zero.

Each side keeps a binary pointer with one extra wrap bit and publishes a Gray-coded copy of it. The other domain samples that copy through two flip-flops before comparing it. A multi-bit pointer change therefore never shows up as a false intermediate value. Each flag sets in the same clock edge that causes it. It clears only once the far side's pointer has come through the two-stage synchronizer, so a flag may stay set a few cycles longer than needed but never clears early. A write while Full and an acknowledge while Empty are both discarded. Each domain has its own active-low asynchronous reset.

Top module: `async_fifo_sa`

## Requirements
- R1: After both resets, empty is 1, full is 0 and rd_data is all zeros.
- R2: Words come out in the order they were written, and up to 8 words (DEPTH = 2**AW with AW = 3) are held at once.
- R3: While empty is 0, rd_data shows the oldest stored word with no read latency. While empty is 1, rd_data is all zeros.
- R4: full goes to 1 in the write clock edge that stores the eighth outstanding word. It is visible before the next write edge, and it stays 0 while fewer words are held.
- R5: A write presented while full is 1 is discarded. The stored words and the write pointer are unchanged.
- R6: empty goes to 1 in the read clock edge that acknowledges the last stored word. rd_data then reads zero.
- R7: An acknowledge while empty is 1 is discarded. The next word written is the next word shown.
- R8: After a write into an empty FIFO, empty stays 1 through the first read clock edge after the write. It is 0 by the third read clock edge.
- R9: After an acknowledge while full, full stays 1 until the write domain has seen the new read pointer through both synchronizer stages. It is 0 within three write clock edges.
- R10: Pointers wrap correctly. Order and data are kept across repeated fill and drain rounds that carry the pointers past their full count range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain asynchronous reset, active low |
| wr_en | input | 1 | Store wr_data on this rising wr_clk edge |
| wr_data | input | W (16) | Word to store |
| full | output | 1 | All entries occupied (write domain) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain asynchronous reset, active low |
| rd_ack | input | 1 | Word on rd_data consumed; advance on this rising rd_clk edge |
| rd_data | output | W (16) | Oldest stored word, zero when empty |
| empty | output | 1 | No word stored (read domain) |

## Verification
The bench checks that Empty is still set one read edge after the first write and clear by the third. A design with only one synchronizer stage, or with no synchronizer, would clear Empty too early. It holds the acknowledge across one read edge while the FIFO is full and checks that Full is still set right after that edge. A design that compared binary pointers directly, or released Full combinationally, would drop Full at once. It pushes a ninth word into a full FIFO and pulses the acknowledge while empty. Either error would show up as a stray word in the drained sequence or as a shifted head word. Repeated fill and drain rounds carry both pointers past their wrap bit. A wrong Full pattern in the Gray code would then report full or empty at the wrong occupancy.

// File: rtl/async_fifo_sa.sv
module async_fifo_sa #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic         wr_clk,
  input  logic         wr_rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  input  logic         rd_clk,
  input  logic         rd_rst_n,
  input  logic         rd_ack,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rgray_q1, rgray_q2;
  logic [PW-1:0] rbin, rgray, wgray_q1, wgray_q2;
  logic [PW-1:0] wbin_nxt, rbin_nxt;
  logic          wr_go, rd_go;

  assign wr_go    = wr_en && !full;
  assign wbin_nxt = wbin + PW'(1);
  assign full     = (wgray == {~rgray_q2[PW-1:PW-2], rgray_q2[PW-3:0]});

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rgray_q1 <= '0;
      rgray_q2 <= '0;
    end else begin
      rgray_q1 <= rgray;
      rgray_q2 <= rgray_q1;
      if (wr_go) begin
        wbin  <= wbin_nxt;
        wgray <= wbin_nxt ^ (wbin_nxt >> 1);
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_go) mem[wbin[AW-1:0]] <= wr_data;

  assign rd_go    = rd_ack && !empty;
  assign rbin_nxt = rbin + PW'(1);
  assign empty    = (rgray == wgray_q2);
  assign rd_data  = empty ? '0 : mem[rbin[AW-1:0]];

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      wgray_q1 <= '0;
      wgray_q2 <= '0;
    end else begin
      wgray_q1 <= wgray;
      wgray_q2 <= wgray_q1;
      if (rd_go) begin
        rbin  <= rbin_nxt;
        rgray <= rbin_nxt ^ (rbin_nxt >> 1);
      end
    end
endmodule

// File: rtl/async_fifo_sa_chk.sv
module async_fifo_sa_chk #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input logic         wr_clk,
  input logic         wr_rst_n,
  input logic         wr_en,
  input logic         full,
  input logic [AW:0]  wptr,
  input logic         rd_clk,
  input logic         rd_rst_n,
  input logic         rd_ack,
  input logic         empty,
  input logic [W-1:0] rd_data,
  input logic [AW:0]  rptr
);
  p_no_overflow_r5: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (full && wr_en) |=> $stable(wptr));

  p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (empty && rd_ack) |=> $stable(rptr));

  p_full_by_write_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $rose(full) |-> $past(wr_en));

  p_empty_by_ack_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(empty) |-> $past(rd_ack));

  p_head_held_r3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!empty && !rd_ack) |=> (!empty && $stable(rd_data)));
endmodule

bind async_fifo_sa async_fifo_sa_chk #(.W(W), .AW(AW)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .full(full), .wptr(wbin),
  .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ack(rd_ack), .empty(empty),
  .rd_data(rd_data), .rptr(rbin)
);

// File: tb/async_fifo_sa_test.sv
`timescale 1ns/1ps
module async_fifo_sa_test;
  localparam int CLK_PERIOD = 4;
  localparam int RD_PERIOD  = CLK_PERIOD * 8 + 2;
  localparam int W = 16;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst_n = 0, rd_rst_n = 0;
  logic wr_en = 0, rd_ack = 0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic full, empty;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  async_fifo_sa uut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_ack(rd_ack), .rd_data(rd_data), .empty(empty)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic push(input logic [W-1:0] d);
    @(negedge wr_clk);
    wr_en = 1; wr_data = d;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_ack = 1;
    @(negedge rd_clk);
    rd_ack = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    #1;
  endtask

  task automatic t_reset();
    wr_rst_n = 0; rd_rst_n = 0; wr_en = 0; rd_ack = 0;
    #(RD_PERIOD * 2);
    check(empty === 1'b1, "R1 empty after reset", 32'(empty), 1);
    check(full === 1'b0, "R1 full after reset", 32'(full), 0);
    check(rd_data === '0, "R1 data after reset", 32'(rd_data), 0);
    @(negedge wr_clk); wr_rst_n = 1;
    @(negedge rd_clk); rd_rst_n = 1;
    settle();
  endtask

  task automatic t_latency();
    push(16'hA55A);
    @(posedge rd_clk); #1;
    check(empty === 1'b1, "R8 empty held one read edge", 32'(empty), 1);
    repeat (2) @(posedge rd_clk); #1;
    check(empty === 1'b0, "R8 empty released by third edge", 32'(empty), 0);
    check(rd_data === 16'hA55A, "R3 show-ahead head word", 32'(rd_data), 32'hA55A);
    pop();
    check(empty === 1'b1, "R6 empty on last ack", 32'(empty), 1);
    check(rd_data === '0, "R3 zero when empty", 32'(rd_data), 0);
    settle();
  endtask

  task automatic t_fill();
    for (int i = 0; i < 8; i++) begin
      check(full === 1'b0, "R4 not full below capacity", 32'(full), 0);
      push(16'h1000 + 16'(i * 17));
    end
    check(full === 1'b1, "R4 full on eighth word", 32'(full), 1);
    push(16'hDEAD);
    check(full === 1'b1, "R5 full still set after blocked write", 32'(full), 1);
    settle();
    check(rd_data === 16'h1000, "R2 first word at head", 32'(rd_data), 32'h1000);
    @(negedge rd_clk); rd_ack = 1;
    @(posedge rd_clk); #1;
    check(full === 1'b1, "R9 full not released at ack edge", 32'(full), 1);
    repeat (3) @(posedge wr_clk); #1;
    check(full === 1'b0, "R9 full released after sync", 32'(full), 0);
    @(negedge rd_clk); rd_ack = 0;
    for (int i = 1; i < 8; i++) begin
      check(rd_data === 16'h1000 + 16'(i * 17), "R2 drain order", 32'(rd_data), 32'(16'h1000 + 16'(i * 17)));
      pop();
    end
    check(empty === 1'b1, "R5 blocked word not stored", 32'(empty), 1);
    check(rd_data === '0, "R5 no stray data", 32'(rd_data), 0);
    settle();
  endtask

  task automatic t_ack_empty();
    pop();
    pop();
    check(empty === 1'b1, "R7 still empty after stray acks", 32'(empty), 1);
    push(16'h7E57);
    settle();
    check(rd_data === 16'h7E57, "R7 head after stray acks", 32'(rd_data), 32'h7E57);
    pop();
    check(empty === 1'b1, "R7 empty after single ack", 32'(empty), 1);
    settle();
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 7; i++) push(16'(r * 256 + i * 3 + 5));
      settle();
      for (int i = 0; i < 7; i++) begin
        check(rd_data === 16'(r * 256 + i * 3 + 5), "R10 wrap order", 32'(rd_data), 32'(16'(r * 256 + i * 3 + 5)));
        pop();
      end
      check(empty === 1'b1, "R10 empty after round", 32'(empty), 1);
      settle();
      check(full === 1'b0, "R10 not full after round", 32'(full), 0);
    end
  endtask

  task automatic t_reset_mid();
    push(16'h0101); push(16'h0202); push(16'h0303);
    settle();
    t_reset();
    push(16'hBEEF);
    settle();
    check(rd_data === 16'hBEEF, "R1 clean restart after reset", 32'(rd_data), 32'hBEEF);
    pop();
    check(empty === 1'b1, "R6 empty after restart drain", 32'(empty), 1);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_fill();
    t_ack_empty();
    t_wrap();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule